// File: doc/BRIEF.md
# STOP-Mode Wake-Up Sequencer

This block takes a low-power controller out of its STOP state when an external interrupt pin becomes active. While the device runs normally, a one-cycle stop request moves it into STOP. In STOP, every interrupt pin reaches the wake logic only if its own enable bit is set. When an enabled pin is high, the block raises the stop release output at once through a purely combinational path, because no clock can be relied on in STOP.

After release, the block walks through three waits in order. The first is a regulator settling interval, counted in pulses of a slow reference tick. The second is oscillator start-up, which ends when a ready input rises. The third is a stabilization interval of a power-of-two number of clock cycles, selected by a 2-bit code. Only after these three waits does the core clock enable return and interrupt acceptance open to every source. During the waits, only the pin that caused the wake is accepted. Interrupts that arrive in this window are collected as pending and do not restart the sequence.

Top module: `stop_wake_ctrl`

## Requirements
- R1: After reset the block is running: `clk_enable`=1, `stop_n`=1, `irq_accept_mask` all ones, `irq_pending`=0.
- R2: A `stop_req` pulse while running enters STOP on the next clock edge: `clk_enable`=0, `irq_accept_mask`=0, and `irq_pending` is cleared. `stop_req` in any other state has no effect.
- R3: In STOP, `stop_n` is the OR over all pins of (`irq_pins[i]` AND `pin_en[i]`). It follows the pins with no clock edge. A pin whose enable bit is 0 cannot release STOP.
- R4: `irq_level` is `irq_pins` delayed through SYNC_STAGES flip-flops (2 by default), forced to 0 while `stop_n`=0. It is independent of `pin_en` outside STOP.
- R5: On the clock edge after release, the block starts the regulator wait. It leaves that wait on the REG_TICKS-th `ref_tick` pulse, and `clk_enable` stays 0 throughout.
- R6: After the regulator wait, the block waits for `osc_ready`. `osc_ready` has no effect before then.
- R7: On the edge where `osc_ready` is taken, `stab_sel` is captured. Codes 0, 1, 2 and 3 give 2^STAB_EXP0 through 2^STAB_EXP3 cycles of stabilization, after which the block is running again.
- R8: From release until running again, `irq_accept_mask` is one-hot on the lowest-index pin that was enabled and high on the release edge. When running, the mask is all ones.
- R9: While waking, `irq_pending` ORs in `irq_level` every cycle and never clears. New requests neither restart nor shorten the wake sequence.
- R10: `clk_enable` is 1 only in the running state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (oscillator domain) |
| rst_n | input | 1 | Asynchronous active-low reset |
| stop_req | input | 1 | One-cycle request to enter STOP |
| irq_pins | input | N_PINS | External interrupt levels, asynchronous |
| pin_en | input | N_PINS | Per-pin wake enable used in STOP |
| ref_tick | input | 1 | Slow reference pulse for the regulator wait |
| osc_ready | input | 1 | Oscillator start-up complete |
| stab_sel | input | 2 | Stabilization length code |
| clk_enable | output | 1 | Core clock enable |
| stop_n | output | 1 | Internal stop signal, low while stopped |
| irq_accept_mask | output | N_PINS | Sources the interrupt logic may accept |
| irq_level | output | N_PINS | Synchronized interrupt levels |
| irq_pending | output | N_PINS | Requests seen during wake-up |

## Verification
On every cycle, the assertions check four things: the mask and clock enable stay consistent, a wake mask is at most one-hot, a stop request enters STOP, and the collected pending bits are sticky. They also check that STOP cannot be left without an enabled active pin. The release with no clock edge, the exact regulator and stabilization lengths for each code, and the choice of the lowest-index waking pin when several pins fire together are shown only by the bench's scenarios. The same holds for the ignored stop requests and ready pulses. The bench compares all of these against its cycle model.

// File: rtl/stop_wake_pkg.sv
package stop_wake_pkg;
   typedef enum logic [2:0] {
      SW_RUN   = 3'd0,
      SW_STOP  = 3'd1,
      SW_REGW  = 3'd2,
      SW_OSCUP = 3'd3,
      SW_STAB  = 3'd4
   } sw_state_t;
endpackage

// File: rtl/wake_sync.sv
module wake_sync #(
   parameter int N      = 8,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] d,
   output logic [N-1:0] q
);
   logic [N-1:0] chain [STAGES];

   genvar s;
   generate
      for (s = 0; s < STAGES; s++) begin : g_stage
         if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[0] <= '0;
               else        chain[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[s] <= '0;
               else        chain[s] <= chain[s-1];
            end
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/wake_gate.sv
module wake_gate #(
   parameter int N = 8
) (
   input  logic [N-1:0] pins,
   input  logic [N-1:0] en,
   output logic         hit,
   output logic [N-1:0] first
);
   logic [N-1:0] gated;

   assign gated = pins & en;
   assign hit   = |gated;
   assign first = gated & (~gated + N'(1));
endmodule

// File: rtl/wake_fsm.sv
module wake_fsm
   import stop_wake_pkg::*;
#(
   parameter int N         = 8,
   parameter int REG_TICKS = 64,
   parameter int STAB_EXP0 = 10,
   parameter int STAB_EXP1 = 13,
   parameter int STAB_EXP2 = 15,
   parameter int STAB_EXP3 = 17
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         stop_req,
   input  logic         hit,
   input  logic [N-1:0] first,
   input  logic         ref_tick,
   input  logic         osc_ready,
   input  logic [1:0]   stab_sel,
   output sw_state_t    state,
   output logic [N-1:0] src
);
   localparam int MAXE = STAB_EXP3;
   localparam int RW   = $clog2(REG_TICKS);
   localparam int CW   = ((MAXE > RW) ? MAXE : RW) + 1;

   sw_state_t    state_q;
   logic [CW-1:0] cnt_q;
   logic [1:0]   sel_q;
   logic [N-1:0] src_q;
   logic [CW-1:0] stab_len;

   always_comb begin
      case (sel_q)
         2'd0:    stab_len = CW'(1) << STAB_EXP0;
         2'd1:    stab_len = CW'(1) << STAB_EXP1;
         2'd2:    stab_len = CW'(1) << STAB_EXP2;
         default: stab_len = CW'(1) << STAB_EXP3;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SW_RUN;
         cnt_q   <= '0;
         sel_q   <= '0;
         src_q   <= '0;
      end else begin
         case (state_q)
            SW_RUN: begin
               if (stop_req) state_q <= SW_STOP;
            end
            SW_STOP: begin
               if (hit) begin
                  state_q <= SW_REGW;
                  src_q   <= first;
                  cnt_q   <= '0;
               end
            end
            SW_REGW: begin
               if (ref_tick) begin
                  if (cnt_q == CW'(REG_TICKS - 1)) begin
                     state_q <= SW_OSCUP;
                     cnt_q   <= '0;
                  end else begin
                     cnt_q <= cnt_q + CW'(1);
                  end
               end
            end
            SW_OSCUP: begin
               if (osc_ready) begin
                  state_q <= SW_STAB;
                  sel_q   <= stab_sel;
                  cnt_q   <= '0;
               end
            end
            SW_STAB: begin
               if (cnt_q == stab_len - CW'(1)) begin
                  state_q <= SW_RUN;
                  cnt_q   <= '0;
               end else begin
                  cnt_q <= cnt_q + CW'(1);
               end
            end
            default: state_q <= SW_RUN;
         endcase
      end
   end

   assign state = state_q;
   assign src   = src_q;
endmodule

// File: rtl/stop_wake_ctrl.sv
module stop_wake_ctrl
   import stop_wake_pkg::*;
#(
   parameter int N_PINS      = 8,
   parameter int SYNC_STAGES = 2,
   parameter int REG_TICKS   = 64,
   parameter int STAB_EXP0   = 10,
   parameter int STAB_EXP1   = 13,
   parameter int STAB_EXP2   = 15,
   parameter int STAB_EXP3   = 17
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              stop_req,
   input  logic [N_PINS-1:0] irq_pins,
   input  logic [N_PINS-1:0] pin_en,
   input  logic              ref_tick,
   input  logic              osc_ready,
   input  logic [1:0]        stab_sel,
   output logic              clk_enable,
   output logic              stop_n,
   output logic [N_PINS-1:0] irq_accept_mask,
   output logic [N_PINS-1:0] irq_level,
   output logic [N_PINS-1:0] irq_pending
);
   generate
      if (N_PINS < 1) begin : g_bad_pins
         $error("N_PINS must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (REG_TICKS < 2) begin : g_bad_reg
         $error("REG_TICKS must be at least 2");
      end
      if (!(STAB_EXP0 <= STAB_EXP1 && STAB_EXP1 <= STAB_EXP2 &&
            STAB_EXP2 <= STAB_EXP3 && STAB_EXP3 <= 30)) begin : g_bad_exp
         $error("STAB_EXPn must be ascending and at most 30");
      end
   endgenerate

   logic              hit;
   logic [N_PINS-1:0] first;
   logic [N_PINS-1:0] sync_lvl;
   sw_state_t         state;
   logic [N_PINS-1:0] src;
   logic [N_PINS-1:0] pend_q;
   logic              waking;

   wake_sync #(.N(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (irq_pins),
      .q     (sync_lvl)
   );

   wake_gate #(.N(N_PINS)) u_gate (
      .pins  (irq_pins),
      .en    (pin_en),
      .hit   (hit),
      .first (first)
   );

   wake_fsm #(
      .N(N_PINS), .REG_TICKS(REG_TICKS),
      .STAB_EXP0(STAB_EXP0), .STAB_EXP1(STAB_EXP1),
      .STAB_EXP2(STAB_EXP2), .STAB_EXP3(STAB_EXP3)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .stop_req  (stop_req),
      .hit       (hit),
      .first     (first),
      .ref_tick  (ref_tick),
      .osc_ready (osc_ready),
      .stab_sel  (stab_sel),
      .state     (state),
      .src       (src)
   );

   assign waking = (state == SW_REGW) || (state == SW_OSCUP) || (state == SW_STAB);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             pend_q <= '0;
      else if (state == SW_RUN && stop_req)   pend_q <= '0;
      else if (waking)                        pend_q <= pend_q | sync_lvl;
   end

   assign clk_enable      = (state == SW_RUN);
   assign stop_n          = (state != SW_STOP) | hit;
   assign irq_accept_mask = (state == SW_RUN)  ? '1 :
                            (state == SW_STOP) ? '0 : src;
   assign irq_level       = stop_n ? sync_lvl : '0;
   assign irq_pending     = pend_q;
endmodule

// File: rtl/stop_wake_chk.sv
module stop_wake_chk #(
   parameter int N = 8
) (
   input logic         clk,
   input logic         rst_n,
   input logic         stop_req,
   input logic [N-1:0] irq_pins,
   input logic [N-1:0] pin_en,
   input logic         clk_enable,
   input logic         stop_n,
   input logic [N-1:0] irq_accept_mask,
   input logic [N-1:0] irq_pending
);
   assert_run_mask_R10: assert property (@(posedge clk) disable iff (!rst_n)
      clk_enable |-> (irq_accept_mask == {N{1'b1}}));

   assert_wake_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !clk_enable |-> $onehot0(irq_accept_mask));

   assert_stop_entry_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (clk_enable && stop_req) |=> !clk_enable);

   assert_gate_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_enable && irq_accept_mask == '0 && (irq_pins & pin_en) == '0) |-> !stop_n);

   assert_no_skip_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_enable && !stop_n) |=> !clk_enable);

   assert_pending_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_enable && $past(!clk_enable)) |->
         ((irq_pending & $past(irq_pending)) == $past(irq_pending)));
endmodule

bind stop_wake_ctrl stop_wake_chk #(.N(N_PINS)) u_chk (
   .clk             (clk),
   .rst_n           (rst_n),
   .stop_req        (stop_req),
   .irq_pins        (irq_pins),
   .pin_en          (pin_en),
   .clk_enable      (clk_enable),
   .stop_n          (stop_n),
   .irq_accept_mask (irq_accept_mask),
   .irq_pending     (irq_pending)
);

// File: tb/test_stop_wake_ctrl.sv
module test_stop_wake_ctrl;
   localparam int NP = 8;
   localparam int RT = 4;
   localparam int E0 = 2, E1 = 3, E2 = 4, E3 = 5;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          stop_req = 1'b0;
   logic [NP-1:0] irq_pins = '0;
   logic [NP-1:0] pin_en = '0;
   logic          ref_tick = 1'b0;
   logic          osc_ready = 1'b0;
   logic [1:0]    stab_sel = '0;
   logic          clk_enable, stop_n;
   logic [NP-1:0] irq_accept_mask, irq_level, irq_pending;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   always #10 clk = ~clk;

   stop_wake_ctrl #(.N_PINS(NP), .SYNC_STAGES(2), .REG_TICKS(RT),
      .STAB_EXP0(E0), .STAB_EXP1(E1), .STAB_EXP2(E2), .STAB_EXP3(E3)) i_stop_wake_ctrl (
      .clk(clk), .rst_n(rst_n), .stop_req(stop_req), .irq_pins(irq_pins),
      .pin_en(pin_en), .ref_tick(ref_tick), .osc_ready(osc_ready),
      .stab_sel(stab_sel), .clk_enable(clk_enable), .stop_n(stop_n),
      .irq_accept_mask(irq_accept_mask), .irq_level(irq_level),
      .irq_pending(irq_pending));

   // reference model: 0 run, 1 stopped, 2 regulator, 3 oscillator, 4 stabilize
   int            m_st = 0;
   int            m_cnt = 0;
   int            m_len = 0;
   logic [NP-1:0] m_src = '0;
   logic [NP-1:0] m_pend = '0;
   logic [NP-1:0] m_hist [$];

   function automatic logic [NP-1:0] lowest(input logic [NP-1:0] v);
      for (int i = 0; i < NP; i++) if (v[i]) return NP'(1) << i;
      return '0;
   endfunction

   function automatic logic [NP-1:0] m_sync();
      return (m_hist.size() >= 2) ? m_hist[1] : '0;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_st = 0; m_cnt = 0; m_len = 0; m_src = '0; m_pend = '0;
         m_hist.delete();
      end else begin
         if (m_st >= 2 && m_st <= 4) m_pend = m_pend | m_sync();
         case (m_st)
            0: if (stop_req) begin m_st = 1; m_pend = '0; end
            1: if ((irq_pins & pin_en) != 0) begin
                  m_st = 2; m_cnt = 0; m_src = lowest(irq_pins & pin_en);
               end
            2: if (ref_tick) begin
                  m_cnt++;
                  if (m_cnt == RT) m_st = 3;
               end
            3: if (osc_ready) begin
                  m_st = 4; m_cnt = 0;
                  m_len = 1 << ((stab_sel == 0) ? E0 : (stab_sel == 1) ? E1 :
                                (stab_sel == 2) ? E2 : E3);
               end
            default: begin
               m_cnt++;
               if (m_cnt == m_len) m_st = 0;
            end
         endcase
         m_hist.push_front(irq_pins);
         if (m_hist.size() > 2) void'(m_hist.pop_back());
      end
   end

   task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   // per-cycle comparison, halfway between the rising and falling edge
   always @(posedge clk) begin
      #5;
      if (rst_n && !done) begin
         logic exp_stop_n;
         exp_stop_n = !(m_st == 1 && (irq_pins & pin_en) == 0);
         chk("R10 clk_enable", NP'(clk_enable), NP'(m_st == 0));
         chk("R3 stop_n", NP'(stop_n), NP'(exp_stop_n));
         chk("R8 accept mask", irq_accept_mask,
             (m_st == 0) ? '1 : (m_st == 1) ? '0 : m_src);
         chk("R4 irq_level", irq_level, exp_stop_n ? m_sync() : '0);
         chk("R9 pending", irq_pending, m_pend);
      end
   end

   // slow reference: one pulse every third cycle
   int tick_div = 0;
   always @(negedge clk) begin
      tick_div = (tick_div == 2) ? 0 : tick_div + 1;
      ref_tick <= (tick_div == 0);
   end

   task automatic cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wait_model(input int st);
      for (int i = 0; i < 2000 && m_st != st; i++) @(negedge clk);
   endtask

   task automatic pulse_stop();
      @(negedge clk); stop_req = 1'b1;
      @(negedge clk); stop_req = 1'b0;
   endtask

   task automatic wake_run(input logic [NP-1:0] en, input logic [NP-1:0] wake,
                           input logic [1:0] sel, input int late_pin);
      pin_en = en;
      pulse_stop();
      chk("R2 stop entered", NP'(clk_enable), NP'(0));
      cyc(3);
      irq_pins = 8'h80 & ~en;               // disabled pin first: no release
      cyc(3);
      chk("R3 disabled pin", NP'(stop_n), NP'(0));
      irq_pins = wake;
      #1;
      chk("R3 release without edge", NP'(stop_n), NP'(1));
      @(negedge clk); irq_pins = '0;
      chk("R8 waking source", irq_accept_mask, lowest(wake & en));
      pulse_stop();                          // ignored while waking (R2)
      wait_model(3);
      stab_sel = sel;
      irq_pins = NP'(1) << late_pin;         // pending during oscillator wait (R9)
      cyc(4);
      irq_pins = '0;
      cyc(2);
      chk("R6 still waiting", NP'(clk_enable), NP'(0));
      osc_ready = 1'b1;
      @(negedge clk); osc_ready = 1'b0; stab_sel = ~sel;
      wait_model(0);
      cyc(1);
      chk("R7 back to run", NP'(clk_enable), NP'(1));
      chk("R9 late source kept", irq_pending & (NP'(1) << late_pin), NP'(1) << late_pin);
   endtask

   initial begin
      cyc(2);
      rst_n = 1'b1;
      cyc(1);
      chk("R1 reset clk_enable", NP'(clk_enable), NP'(1));
      chk("R1 reset mask", irq_accept_mask, '1);
      chk("R1 reset pending", irq_pending, '0);
      osc_ready = 1'b1; cyc(3); osc_ready = 1'b0;   // R6: no effect in run
      irq_pins = 8'h3C; cyc(4);                      // R4: level path with enables 0
      irq_pins = '0; cyc(3);
      wake_run(8'h04, 8'h04, 2'd1, 5);
      wake_run(8'h05, 8'h05, 2'd0, 6);
      wake_run(8'hFF, 8'h48, 2'd2, 1);
      wake_run(8'h21, 8'h20, 2'd3, 7);
      osc_ready = 1'b1; pin_en = 8'h02;              // R6: early ready ignored
      pulse_stop();
      irq_pins = 8'h02; @(negedge clk); irq_pins = '0;
      cyc(3);
      chk("R5 regulator wait holds", NP'(clk_enable), NP'(0));
      osc_ready = 1'b0;
      wait_model(3); cyc(5);
      osc_ready = 1'b1; @(negedge clk); osc_ready = 1'b0;
      wait_model(0); cyc(2);
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule